// File: doc/BRIEF.md
# Binary and Decimal ALU with Correction Constant

This block is the arithmetic unit of an 8-bit processor datapath. A function code selects one of twelve operations on two operands: pass, add with carry, subtract with borrow, three bitwise operations, increment, decrement and four single-bit shifts. The unit returns the result together with carry, zero, negative and overflow flags. It also returns a carry for program-counter arithmetic that can be read as a borrow when a branch offset is negative. The result and flags are combinational.

Packed decimal arithmetic takes two passes. On the first pass, an add or subtract raises a per-nibble flag whenever that nibble leaves the decimal range. A small clocked register turns those flags into a correction constant of 0x00, 0x06, 0x60 or 0x66. On the second pass, the sequencer adds or subtracts that constant to turn the binary result into a valid decimal one. The sequencer stays outside the block. It drives the function code, the bypass, the decimal-mode enable, the opcode-fetch clear and the wait hold.

Top module: `bcd_alu_unit`

## Requirements
- R1: With funcCode 4'b0000, or with bypass high (whatever funcCode is), result equals opA, carryOut equals carryIn and ovfOut equals ovfIn. When bypass is high, nibLoOvf, nibHiOvf and pcCarry are all 0.
- R2: funcCode 4'b0001 gives result = (opA + opB + carryIn) mod 256. carryOut is the ninth sum bit. ovfOut is set when both operands share a sign bit and the result's sign differs from it.
- R3: funcCode 4'b0010 gives result = (opA - opB - carryIn) mod 256. carryOut is 1 exactly when a borrow occurs (opA < opB + carryIn). ovfOut is set when the operand signs differ and the result's sign differs from opA's.
- R4: funcCodes 4'b0011, 4'b0100 and 4'b0101 give opA AND, OR and XOR opB. carryOut equals carryIn and ovfOut equals ovfIn.
- R5: funcCode 4'b0110 gives opA + 1 and 4'b0111 gives opA - 1, both wrapping modulo 256. carryOut and ovfOut pass through.
- R6: funcCode 4'b1000 shifts left with a 0 fill. 4'b1001 shifts right with a 0 fill. 4'b1010 rotates left with carryIn entering bit 0. 4'b1011 rotates right with carryIn entering bit 7. For left moves carryOut takes opA bit 7; for right moves it takes opA bit 0. ovfOut passes through.
- R7: For every operation, zeroOut is 1 exactly when result is 0x00, and negOut equals result bit 7.
- R8: On an add, nibLoOvf is set when low(opA) + low(opB) + carryIn exceeds 9. nibHiOvf is set when high(opA) + high(opB) + nibLoOvf exceeds 9.
- R9: On a subtract, nibLoOvf is set when low(opA) < low(opB) + carryIn. nibHiOvf is set when high(opA) < high(opB) + nibLoOvf. On every other operation both flags are 0.
- R10: On an add, pcCarry equals carryOut when branchNeg is 0 and the inverse of carryOut when branchNeg is 1. On every other operation it is 0.
- R11: On a rising clock edge with waitHold low, fetchClr low and decMode high, adjConst loads 0x6 into its low nibble if nibLoOvf is set (0x0 otherwise) and 0x6 into its high nibble if nibHiOvf is set (0x0 otherwise). With decMode low it holds.
- R12: adjConst is 0x00 during reset. On an edge with waitHold low and fetchClr high it clears to 0x00. On any edge with waitHold high it holds.
- R13: The unused funcCodes 4'b1100 through 4'b1111 behave like pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the correction register |
| rst_n | input | 1 | Asynchronous active-low reset |
| funcCode | input | 4 | Operation select |
| branchNeg | input | 1 | Branch offset is negative; turns pcCarry into a borrow |
| bypass | input | 1 | Forces a pass of opA |
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| carryIn | input | 1 | Carry or borrow in, rotate fill |
| ovfIn | input | 1 | Overflow flag passed through by non-arithmetic ops |
| decMode | input | 1 | Decimal mode; enables loading of adjConst |
| fetchClr | input | 1 | Opcode fetch; clears adjConst |
| waitHold | input | 1 | Wait state; freezes adjConst |
| result | output | 8 | Operation result |
| carryOut | output | 1 | Carry or borrow out |
| zeroOut | output | 1 | Result is zero |
| negOut | output | 1 | Result bit 7 |
| ovfOut | output | 1 | Signed overflow |
| pcCarry | output | 1 | Carry or borrow for program-counter high byte |
| nibLoOvf | output | 1 | Low nibble left decimal range |
| nibHiOvf | output | 1 | High nibble left decimal range |
| adjConst | output | 8 | Decimal correction constant |

## Verification
The result, all flags and both nibble flags are due in the same cycle as the operands that produce them. adjConst is due after the first rising edge that follows the operands, since it comes from the nibble flags through one register. The driver applies each stimulus at the falling edge and records the expected combinational values. It also advances its own model of the correction register by the edge that has just passed, so each queued item carries the adjConst value due at that moment. The monitor compares each item 4 ns after the falling edge, well clear of the next rising edge.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam logic [3:0] FN_PASS = 4'h0;
  localparam logic [3:0] FN_ADD  = 4'h1;
  localparam logic [3:0] FN_SUB  = 4'h2;
  localparam logic [3:0] FN_AND  = 4'h3;
  localparam logic [3:0] FN_OR   = 4'h4;
  localparam logic [3:0] FN_XOR  = 4'h5;
  localparam logic [3:0] FN_INC  = 4'h6;
  localparam logic [3:0] FN_DEC  = 4'h7;
  localparam logic [3:0] FN_ASL  = 4'h8;
  localparam logic [3:0] FN_LSR  = 4'h9;
  localparam logic [3:0] FN_ROL  = 4'hA;
  localparam logic [3:0] FN_ROR  = 4'hB;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logicSel_t;

  typedef struct packed {
    logic      doAdd;
    logic      doSub;
    logic      doLogic;
    logicSel_t logicSel;
    logic      doStep;
    logic      stepDown;
    logic      doShift;
    logic      shiftRight;
    logic      shiftRot;
  } aluStrobes_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0]  funcCode,
  input  logic        bypass,
  output aluStrobes_t strobes
);

  always_comb begin
    strobes          = '0;
    strobes.logicSel = LG_AND;
    if (!bypass) begin
      unique case (funcCode)
        FN_ADD: strobes.doAdd = 1'b1;
        FN_SUB: strobes.doSub = 1'b1;
        FN_AND: begin strobes.doLogic = 1'b1; strobes.logicSel = LG_AND; end
        FN_OR:  begin strobes.doLogic = 1'b1; strobes.logicSel = LG_OR;  end
        FN_XOR: begin strobes.doLogic = 1'b1; strobes.logicSel = LG_XOR; end
        FN_INC: strobes.doStep = 1'b1;
        FN_DEC: begin strobes.doStep = 1'b1; strobes.stepDown = 1'b1; end
        FN_ASL: strobes.doShift = 1'b1;
        FN_LSR: begin strobes.doShift = 1'b1; strobes.shiftRight = 1'b1; end
        FN_ROL: begin strobes.doShift = 1'b1; strobes.shiftRot = 1'b1; end
        FN_ROR: begin
          strobes.doShift    = 1'b1;
          strobes.shiftRight = 1'b1;
          strobes.shiftRot   = 1'b1;
        end
        default: strobes.logicSel = LG_AND;
      endcase
    end
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluStrobes_t       strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic              ovfIn,
  input  logic              branchNeg,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              zeroOut,
  output logic              negOut,
  output logic              ovfOut,
  output logic              pcCarry,
  output logic              nibLoOvf,
  output logic              nibHiOvf
);

  localparam int HALF_W = DATA_W / 2;
  localparam int MSB    = DATA_W - 1;
  localparam logic [HALF_W:0] DEC_LIMIT = (HALF_W + 1)'(9);

  // full-width add and subtract
  logic [DATA_W:0] addSum;
  logic [DATA_W:0] subDiff;
  logic            carryIntoMsb;
  logic            addOvf;
  logic            subOvf;

  assign addSum  = {1'b0, opA} + {1'b0, opB} + {{DATA_W{1'b0}}, carryIn};
  assign subDiff = {1'b0, opA} - {1'b0, opB} - {{DATA_W{1'b0}}, carryIn};
  assign carryIntoMsb = opA[MSB] ^ opB[MSB] ^ addSum[MSB];
  assign addOvf = carryIntoMsb ^ addSum[DATA_W];
  assign subOvf = (opA[MSB] ^ opB[MSB]) & (opA[MSB] ^ subDiff[MSB]);

  // per-half decimal range detection
  logic [HALF_W-1:0] aLo, aHi, bLo, bHi;
  logic [HALF_W:0]   loAdd, hiAdd, loSubNeed, hiSubNeed;
  logic              loAddOvf, hiAddOvf, loSubOvf, hiSubOvf;

  assign aLo = opA[HALF_W-1:0];
  assign aHi = opA[DATA_W-1:HALF_W];
  assign bLo = opB[HALF_W-1:0];
  assign bHi = opB[DATA_W-1:HALF_W];

  assign loAdd    = {1'b0, aLo} + {1'b0, bLo} + {{HALF_W{1'b0}}, carryIn};
  assign loAddOvf = loAdd > DEC_LIMIT;
  assign hiAdd    = {1'b0, aHi} + {1'b0, bHi} + {{HALF_W{1'b0}}, loAddOvf};
  assign hiAddOvf = hiAdd > DEC_LIMIT;

  assign loSubNeed = {1'b0, bLo} + {{HALF_W{1'b0}}, carryIn};
  assign loSubOvf  = {1'b0, aLo} < loSubNeed;
  assign hiSubNeed = {1'b0, bHi} + {{HALF_W{1'b0}}, loSubOvf};
  assign hiSubOvf  = {1'b0, aHi} < hiSubNeed;

  // result and flag selection
  logic shiftFill;
  assign shiftFill = strobes.shiftRot ? carryIn : 1'b0;

  always_comb begin
    result   = opA;
    carryOut = carryIn;
    ovfOut   = ovfIn;
    if (strobes.doAdd) begin
      result   = addSum[DATA_W-1:0];
      carryOut = addSum[DATA_W];
      ovfOut   = addOvf;
    end else if (strobes.doSub) begin
      result   = subDiff[DATA_W-1:0];
      carryOut = subDiff[DATA_W];
      ovfOut   = subOvf;
    end else if (strobes.doLogic) begin
      unique case (strobes.logicSel)
        LG_AND:  result = opA & opB;
        LG_OR:   result = opA | opB;
        LG_XOR:  result = opA ^ opB;
        default: result = opA;
      endcase
    end else if (strobes.doStep) begin
      result = strobes.stepDown ? opA - 1'b1 : opA + 1'b1;
    end else if (strobes.doShift) begin
      if (strobes.shiftRight) begin
        result   = {shiftFill, opA[MSB:1]};
        carryOut = opA[0];
      end else begin
        result   = {opA[MSB-1:0], shiftFill};
        carryOut = opA[MSB];
      end
    end
  end

  assign zeroOut  = (result == '0);
  assign negOut   = result[MSB];
  assign nibLoOvf = (strobes.doAdd & loAddOvf) | (strobes.doSub & loSubOvf);
  assign nibHiOvf = (strobes.doAdd & hiAddOvf) | (strobes.doSub & hiSubOvf);
  assign pcCarry  = strobes.doAdd & (addSum[DATA_W] ^ branchNeg);

endmodule

// File: rtl/adj_const_reg.sv
module adj_const_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              decMode,
  input  logic              fetchClr,
  input  logic              waitHold,
  input  logic              nibLoOvf,
  input  logic              nibHiOvf,
  output logic [DATA_W-1:0] adjConst
);

  localparam int HALF_W = DATA_W / 2;
  localparam logic [HALF_W-1:0] SIX = HALF_W'(6);

  logic [1:0] halfFlag;
  assign halfFlag = {nibHiOvf, nibLoOvf};

  for (genvar g = 0; g < 2; g++) begin : g_half
    logic [HALF_W-1:0] halfReg;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        halfReg <= '0;
      end else if (!waitHold) begin
        if (fetchClr)     halfReg <= '0;
        else if (decMode) halfReg <= halfFlag[g] ? SIX : '0;
      end
    end

    assign adjConst[g*HALF_W +: HALF_W] = halfReg;

    p_half_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!waitHold && !fetchClr && decMode) |=>
        (adjConst[g*HALF_W +: HALF_W] == ($past(halfFlag[g]) ? SIX : '0)));
  end

  p_hold_on_wait_r12: assert property (@(posedge clk) disable iff (!rst_n)
    waitHold |=> $stable(adjConst));

  p_clear_on_fetch_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!waitHold && fetchClr) |=> (adjConst == '0));

  p_binary_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!waitHold && !fetchClr && !decMode) |=> $stable(adjConst));

endmodule

// File: rtl/bcd_alu_unit.sv
module bcd_alu_unit
  import alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        funcCode,
  input  logic              branchNeg,
  input  logic              bypass,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic              ovfIn,
  input  logic              decMode,
  input  logic              fetchClr,
  input  logic              waitHold,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              zeroOut,
  output logic              negOut,
  output logic              ovfOut,
  output logic              pcCarry,
  output logic              nibLoOvf,
  output logic              nibHiOvf,
  output logic [DATA_W-1:0] adjConst
);

  aluStrobes_t strobes;

  alu_ctrl u_ctrl (
    .funcCode (funcCode),
    .bypass   (bypass),
    .strobes  (strobes)
  );

  alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .strobes   (strobes),
    .opA       (opA),
    .opB       (opB),
    .carryIn   (carryIn),
    .ovfIn     (ovfIn),
    .branchNeg (branchNeg),
    .result    (result),
    .carryOut  (carryOut),
    .zeroOut   (zeroOut),
    .negOut    (negOut),
    .ovfOut    (ovfOut),
    .pcCarry   (pcCarry),
    .nibLoOvf  (nibLoOvf),
    .nibHiOvf  (nibHiOvf)
  );

  adj_const_reg #(.DATA_W(DATA_W)) u_adj (
    .clk      (clk),
    .rst_n    (rst_n),
    .decMode  (decMode),
    .fetchClr (fetchClr),
    .waitHold (waitHold),
    .nibLoOvf (nibLoOvf),
    .nibHiOvf (nibHiOvf),
    .adjConst (adjConst)
  );

  p_bypass_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (result == opA && carryOut == carryIn && ovfOut == ovfIn &&
                !nibLoOvf && !nibHiOvf && !pcCarry));

  p_no_nibble_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (funcCode != FN_ADD && funcCode != FN_SUB) |-> (!nibLoOvf && !nibHiOvf));

  p_pc_carry_only_add_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass || funcCode != FN_ADD) |-> !pcCarry);

  p_logic_flags_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && (funcCode == FN_AND || funcCode == FN_OR || funcCode == FN_XOR))
      |-> (carryOut == carryIn && ovfOut == ovfIn));

endmodule

// File: tb/bcd_alu_unit_test.sv
module bcd_alu_unit_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic [3:0] funcCode;
  logic       branchNeg, bypass, carryIn, ovfIn, decMode, fetchClr, waitHold;
  logic [7:0] opA, opB;
  logic [7:0] result, adjConst;
  logic       carryOut, zeroOut, negOut, ovfOut, pcCarry, nibLoOvf, nibHiOvf;

  bcd_alu_unit uut (
    .clk(clk), .rst_n(rst_n), .funcCode(funcCode), .branchNeg(branchNeg),
    .bypass(bypass), .opA(opA), .opB(opB), .carryIn(carryIn), .ovfIn(ovfIn),
    .decMode(decMode), .fetchClr(fetchClr), .waitHold(waitHold),
    .result(result), .carryOut(carryOut), .zeroOut(zeroOut), .negOut(negOut),
    .ovfOut(ovfOut), .pcCarry(pcCarry), .nibLoOvf(nibLoOvf), .nibHiOvf(nibHiOvf),
    .adjConst(adjConst)
  );

  typedef struct {
    string      tag;
    logic [7:0] res;
    logic       c, z, n, v, pc, lo, hi;
    logic [7:0] adj;
  } expItem_t;

  expItem_t scoreQ[$];
  int checks = 0;
  int fails  = 0;
  logic [7:0] adjModel = 8'h00;
  logic prevLo = 1'b0, prevHi = 1'b0;

  // expected values from the requirements
  function automatic expItem_t predict(logic [3:0] fc, logic [7:0] a, logic [7:0] b,
                                       logic ci, logic vi, logic byp, logic bn);
    expItem_t e;
    int s;
    e.res = a; e.c = ci; e.v = vi; e.pc = 1'b0; e.lo = 1'b0; e.hi = 1'b0;
    if (!byp) begin
      case (fc)
        4'h1: begin
          s = int'(a) + int'(b) + int'(ci);
          e.res = 8'(s);
          e.c   = (s > 255);
          e.v   = (a[7] == b[7]) && (e.res[7] != a[7]);
          e.lo  = (int'(a % 16) + int'(b % 16) + int'(ci)) > 9;
          e.hi  = (int'(a / 16) + int'(b / 16) + int'(e.lo)) > 9;
          e.pc  = bn ? !e.c : e.c;
        end
        4'h2: begin
          s = int'(a) - int'(b) - int'(ci);
          e.res = 8'(s);
          e.c   = (s < 0);
          e.v   = (a[7] != b[7]) && (e.res[7] != a[7]);
          e.lo  = int'(a % 16) < (int'(b % 16) + int'(ci));
          e.hi  = int'(a / 16) < (int'(b / 16) + int'(e.lo));
        end
        4'h3: e.res = a & b;
        4'h4: e.res = a | b;
        4'h5: e.res = a ^ b;
        4'h6: e.res = 8'(int'(a) + 1);
        4'h7: e.res = 8'(int'(a) + 255);
        4'h8: begin e.res = {a[6:0], 1'b0}; e.c = a[7]; end
        4'h9: begin e.res = {1'b0, a[7:1]}; e.c = a[0]; end
        4'hA: begin e.res = {a[6:0], ci};   e.c = a[7]; end
        4'hB: begin e.res = {ci, a[7:1]};   e.c = a[0]; end
        default: ;
      endcase
    end
    e.z = (e.res == 8'h00);
    e.n = e.res[7];
    return e;
  endfunction

  task automatic drive(string tag, logic [3:0] fc, logic [7:0] a, logic [7:0] b,
                       logic ci, logic vi, logic byp, logic bn,
                       logic dm, logic fe, logic wt);
    expItem_t e;
    @(negedge clk);
    // advance the register model over the edge just passed
    if (!waitHold) begin
      if (fetchClr)     adjModel = 8'h00;
      else if (decMode) adjModel = {prevHi ? 4'h6 : 4'h0, prevLo ? 4'h6 : 4'h0};
    end
    funcCode = fc; opA = a; opB = b; carryIn = ci; ovfIn = vi; bypass = byp;
    branchNeg = bn; decMode = dm; fetchClr = fe; waitHold = wt;
    e = predict(fc, a, b, ci, vi, byp, bn);
    e.tag = tag;
    e.adj = adjModel;
    prevLo = e.lo; prevHi = e.hi;
    scoreQ.push_back(e);
  endtask

  // monitor
  initial begin
    expItem_t e;
    forever begin
      @(negedge clk);
      #4;
      if (scoreQ.size() > 0) begin
        e = scoreQ.pop_front();
        checks++;
        if (result !== e.res || carryOut !== e.c || zeroOut !== e.z || negOut !== e.n ||
            ovfOut !== e.v || pcCarry !== e.pc || nibLoOvf !== e.lo || nibHiOvf !== e.hi ||
            adjConst !== e.adj) begin
          fails++;
          $display("FAIL %s: got res=%h c=%b z=%b n=%b v=%b pc=%b lo=%b hi=%b adj=%h, expected res=%h c=%b z=%b n=%b v=%b pc=%b lo=%b hi=%b adj=%h",
                   e.tag, result, carryOut, zeroOut, negOut, ovfOut, pcCarry, nibLoOvf,
                   nibHiOvf, adjConst, e.res, e.c, e.z, e.n, e.v, e.pc, e.lo, e.hi, e.adj);
        end
      end
    end
  end

  // watchdog
  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    funcCode = 4'h0; opA = 8'h00; opB = 8'h00; carryIn = 1'b0; ovfIn = 1'b0;
    bypass = 1'b0; branchNeg = 1'b0; decMode = 1'b0; fetchClr = 1'b0; waitHold = 1'b0;
    repeat (2) @(negedge clk);
    #4;
    checks++;
    if (adjConst !== 8'h00) begin
      fails++;
      $display("FAIL R12 reset: got adj=%h, expected adj=00", adjConst);
    end
    @(negedge clk);
    rst_n = 1'b1;

    //     tag               fc    a      b      ci    vi    byp   bn    dm    fe    wt
    drive("R1 pass",        4'h0, 8'h5A, 8'h11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R1 bypass add",  4'h1, 8'h80, 8'h80, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    drive("R7 pass zero",   4'h0, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R2 add ovf",     4'h1, 8'h7F, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R2 add carry",   4'h1, 8'hFF, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R2 add cin",     4'h1, 8'h12, 8'h34, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R3 sub plain",   4'h2, 8'h50, 8'h20, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R3 sub borrow",  4'h2, 8'h00, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R3 sub ovf",     4'h2, 8'h80, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R3 sub bin",     4'h2, 8'h34, 8'h12, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R4 and",         4'h3, 8'hF0, 8'h3C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    drive("R4 or",          4'h4, 8'h0F, 8'h30, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R4 xor",         4'h5, 8'hAA, 8'hAA, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R5 inc wrap",    4'h6, 8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R5 dec wrap",    4'h7, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R6 asl",         4'h8, 8'h81, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R6 lsr",         4'h9, 8'h81, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R6 rol",         4'hA, 8'h81, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R6 ror",         4'hB, 8'h81, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R13 code C",     4'hC, 8'h9E, 8'h11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R13 code F",     4'hF, 8'h00, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R10 neg carry",  4'h1, 8'h10, 8'hF0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    drive("R10 neg borrow", 4'h1, 8'h10, 8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    drive("R10 pos carry",  4'h1, 8'hF0, 8'h20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // decimal add 09+01 then correction pass
    drive("R8 dec add lo",  4'h1, 8'h09, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    drive("R11 fix 06",     4'h1, 8'h0A, 8'h06, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R8 dec add both",4'h1, 8'h99, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    drive("R11 fix 66",     4'h1, 8'h9A, 8'h66, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R8 dec add 8+8", 4'h1, 8'h08, 8'h08, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    // decimal subtract
    drive("R9 dec sub both",4'h2, 8'h00, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    drive("R11 sub fix 66", 4'h2, 8'hFF, 8'h66, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R9 dec sub lo",  4'h2, 8'h10, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    drive("R11 sub fix 06", 4'h2, 8'h0F, 8'h06, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // hold in wait, then binary hold, then fetch clear
    drive("R12 wait",       4'h1, 8'h99, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    drive("R12 wait held",  4'h0, 8'h33, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R11 bin held",   4'h1, 8'h99, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    drive("R12 fetch clr",  4'h0, 8'h44, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    drive("R9 logic dec",   4'h4, 8'h99, 8'h99, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    drive("R9 logic zero",  4'h0, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule